// File: doc/BRIEF.md
# Branch Target Buffer with Zero-Cycle Folding

This block is a fetch-stage predictor. The fetch unit presents the PC of the word it is about to fetch, before the word is decoded. The block looks the PC up in a direct-mapped table of recently taken branches. On a match it gives the next fetch address to use, which is the stored target. On a miss it gives the sequential address, PC + 4.

Each entry also holds the instruction found at the branch target. When the matching branch is unconditional, the block raises a fold flag. The fetch unit then drops the branch itself and issues the stored target instruction in its place. The branch costs no issue slot, and its only effect is the PC change.

The execute stage keeps the table up to date through an update port. A taken branch writes or overwrites its entry. A conditional branch that resolved not-taken clears the valid bit at its index. Lookups are pipelined: the response appears two cycles after the request, and a new lookup can be accepted every cycle.

Top module: `btb_fold_top`

## Requirements
- R1: After reset, no entry is valid. Every lookup misses until a taken update has been made.
- R2: A lookup accepted at a clock edge gives `rsp_valid` high exactly two edges later. This holds for a lookup in every cycle.
- R3: After a taken update for PC P with target T, a lookup of P hits and returns `rsp_next_pc` = T.
- R4: A lookup that misses returns `rsp_hit`=0, `rsp_fold`=0, `rsp_instr`=0 and `rsp_next_pc` = PC + 4.
- R5: The table is direct-mapped. The index is PC bits [IDX_W+1:2], and the tag is all PC bits above the index. A PC with the same index as a stored entry but a different tag misses.
- R6: An update with `upd_taken`=0 and `upd_uncond`=0 clears the entry at that PC's index, so a later lookup there misses.
- R7: On a hit, `rsp_instr` carries the stored target instruction. `rsp_fold` is 1 only when the hit entry was written with `upd_uncond`=1 and the FOLD_EN parameter is 1 (the default).
- R8: A lookup and an update to the same index at the same edge return the contents the entry had before that update.
- R9: A taken update to an index that already holds an entry replaces the target, the instruction and the unconditional mark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lkp_valid | input | 1 | Lookup request strobe |
| lkp_pc | input | ADDR_W | PC to look up |
| upd_valid | input | 1 | Update strobe from execute |
| upd_pc | input | ADDR_W | PC of the resolved branch |
| upd_target | input | ADDR_W | Resolved branch target |
| upd_taken | input | 1 | Branch was taken |
| upd_uncond | input | 1 | Branch is unconditional |
| upd_instr | input | INSTR_W | Instruction word at the target |
| rsp_valid | output | 1 | Response strobe, two cycles after the lookup |
| rsp_hit | output | 1 | Lookup matched a valid entry |
| rsp_next_pc | output | ADDR_W | Predicted next fetch address |
| rsp_instr | output | INSTR_W | Stored target instruction, zero on a miss |
| rsp_fold | output | 1 | Drop the branch and issue `rsp_instr` in its place |

## Verification
Every lookup result is due two clock edges after the edge that accepts it. The first edge registers the table read. The second edge registers the compare and the output fields.

The bench computes the expected response when it drives the lookup, using its own table model in the state it has before any update driven in the same cycle. It queues that expectation. A monitor samples on the falling edge and pops one entry each time `rsp_valid` is high, so lookups may stream back to back without a fixed wait. An unexpected `rsp_valid`, or expectations left in the queue at the end, count as failures.

// File: rtl/btb_pkg.sv
package btb_pkg;

  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_WRITE = 2'd1,
    ACT_CLEAR = 2'd2
  } btb_act_e;

  // taken branches install, resolved not-taken conditionals evict
  function automatic btb_act_e upd_action(input logic v, input logic taken,
                                          input logic uncond);
    if (!v)          return ACT_NONE;
    else if (taken)  return ACT_WRITE;
    else if (!uncond) return ACT_CLEAR;
    else             return ACT_NONE;
  endfunction

endpackage

// File: rtl/btb_pc_split.sv
module btb_pc_split #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4,
  localparam int TAG_W = ADDR_W - IDX_W - 2
) (
  input  logic [ADDR_W-1:0] pc,
  output logic [IDX_W-1:0]  idx,
  output logic [TAG_W-1:0]  tag
);
  assign idx = pc[IDX_W+1:2];
  assign tag = pc[ADDR_W-1:IDX_W+2];
endmodule

// File: rtl/btb_store.sv
module btb_store
  import btb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 32,
  parameter int INSTR_W = 32,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int TAG_W  = ADDR_W - IDX_W - 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_en,
  input  logic [IDX_W-1:0]   rd_idx,
  input  btb_act_e           act,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [TAG_W-1:0]   wr_tag,
  input  logic [ADDR_W-1:0]  wr_target,
  input  logic [INSTR_W-1:0] wr_instr,
  input  logic               wr_uncond,
  output logic               rd_vld,
  output logic [TAG_W-1:0]   rd_tag,
  output logic [ADDR_W-1:0]  rd_target,
  output logic [INSTR_W-1:0] rd_instr,
  output logic               rd_uncond
);
  localparam int DW = TAG_W + ADDR_W + INSTR_W + 1;

  logic [ENTRIES-1:0] vld_q;
  logic [DW-1:0]      mem [ENTRIES];
  logic [DW-1:0]      rd_q;
  logic               rd_vld_q;

  // valid bits live in flops so reset can clear them in one cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
    end else begin
      case (act)
        ACT_WRITE: vld_q[wr_idx] <= 1'b1;
        ACT_CLEAR: vld_q[wr_idx] <= 1'b0;
        default:   ;
      endcase
    end
  end

  // payload array: one write port, one read-first registered read port
  always_ff @(posedge clk) begin
    if (act == ACT_WRITE)
      mem[wr_idx] <= {wr_tag, wr_target, wr_instr, wr_uncond};
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_q <= mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_vld_q <= 1'b0;
    else if (rd_en) rd_vld_q <= vld_q[rd_idx];
  end

  assign rd_vld = rd_vld_q;
  assign {rd_tag, rd_target, rd_instr, rd_uncond} = rd_q;

  // R3: a taken update leaves its index valid
  a_r3_write_sets_valid: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_WRITE) |=> vld_q[$past(wr_idx)]);

  // R6: a not-taken conditional update leaves its index invalid
  a_r6_clear_drops_valid: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_CLEAR) |=> !vld_q[$past(wr_idx)]);

endmodule

// File: rtl/btb_resp.sv
module btb_resp #(
  parameter int ADDR_W  = 32,
  parameter int INSTR_W = 32,
  parameter int IDX_W   = 4,
  parameter bit FOLD_EN = 1'b1,
  localparam int TAG_W  = ADDR_W - IDX_W - 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               lkp_valid,
  input  logic [ADDR_W-1:0]  lkp_pc,
  input  logic               rd_vld,
  input  logic [TAG_W-1:0]   rd_tag,
  input  logic [ADDR_W-1:0]  rd_target,
  input  logic [INSTR_W-1:0] rd_instr,
  input  logic               rd_uncond,
  output logic               rsp_valid,
  output logic               rsp_hit,
  output logic [ADDR_W-1:0]  rsp_next_pc,
  output logic [INSTR_W-1:0] rsp_instr,
  output logic               rsp_fold
);
  logic              s1_valid_q;
  logic [ADDR_W-1:0] s1_pc_q;
  logic [IDX_W-1:0]  s1_idx;
  logic [TAG_W-1:0]  s1_tag;
  logic              match;
  logic              fold_d;

  // stage 1 travels alongside the table read
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid_q <= 1'b0;
      s1_pc_q    <= '0;
    end else begin
      s1_valid_q <= lkp_valid;
      if (lkp_valid) s1_pc_q <= lkp_pc;
    end
  end

  btb_pc_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_s1_split (
    .pc(s1_pc_q), .idx(s1_idx), .tag(s1_tag)
  );

  assign match = rd_vld && (rd_tag == s1_tag);

  generate
    if (FOLD_EN) begin : g_fold
      assign fold_d = match && rd_uncond;
    end else begin : g_nofold
      assign fold_d = 1'b0;
    end
  endgenerate

  // stage 2: registered response
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_hit     <= 1'b0;
      rsp_next_pc <= '0;
      rsp_instr   <= '0;
      rsp_fold    <= 1'b0;
    end else begin
      rsp_valid <= s1_valid_q;
      if (s1_valid_q) begin
        rsp_hit     <= match;
        rsp_next_pc <= match ? rd_target : s1_pc_q + ADDR_W'(4);
        rsp_instr   <= match ? rd_instr : '0;
        rsp_fold    <= fold_d;
      end else begin
        rsp_hit  <= 1'b0;
        rsp_fold <= 1'b0;
      end
    end
  end

  // R4: a miss carries no instruction and never folds
  a_r4_miss_clean: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> (!rsp_fold && rsp_instr == '0));

  // R7: folding requires a hit
  a_r7_fold_needs_hit: assert property (@(posedge clk) disable iff (rst)
    rsp_fold |-> rsp_hit);

  // R1: hit is only ever reported inside a response
  a_r1_hit_in_rsp: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> rsp_valid);

endmodule

// File: rtl/btb_fold_top.sv
module btb_fold_top
  import btb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 32,
  parameter int INSTR_W = 32,
  parameter bit FOLD_EN = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               lkp_valid,
  input  logic [ADDR_W-1:0]  lkp_pc,
  input  logic               upd_valid,
  input  logic [ADDR_W-1:0]  upd_pc,
  input  logic [ADDR_W-1:0]  upd_target,
  input  logic               upd_taken,
  input  logic               upd_uncond,
  input  logic [INSTR_W-1:0] upd_instr,
  output logic               rsp_valid,
  output logic               rsp_hit,
  output logic [ADDR_W-1:0]  rsp_next_pc,
  output logic [INSTR_W-1:0] rsp_instr,
  output logic               rsp_fold
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = ADDR_W - IDX_W - 2;

  logic [IDX_W-1:0]   l_idx, u_idx;
  logic [TAG_W-1:0]   l_tag, u_tag;
  btb_act_e           act;
  logic               rd_vld, rd_uncond;
  logic [TAG_W-1:0]   rd_tag;
  logic [ADDR_W-1:0]  rd_target;
  logic [INSTR_W-1:0] rd_instr;

  btb_pc_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_lkp_split (
    .pc(lkp_pc), .idx(l_idx), .tag(l_tag)
  );

  btb_pc_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_upd_split (
    .pc(upd_pc), .idx(u_idx), .tag(u_tag)
  );

  assign act = upd_action(upd_valid, upd_taken, upd_uncond);

  btb_store #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .INSTR_W(INSTR_W)) u_store (
    .clk(clk), .rst(rst),
    .rd_en(lkp_valid), .rd_idx(l_idx),
    .act(act), .wr_idx(u_idx), .wr_tag(u_tag),
    .wr_target(upd_target), .wr_instr(upd_instr), .wr_uncond(upd_uncond),
    .rd_vld(rd_vld), .rd_tag(rd_tag), .rd_target(rd_target),
    .rd_instr(rd_instr), .rd_uncond(rd_uncond)
  );

  btb_resp #(.ADDR_W(ADDR_W), .INSTR_W(INSTR_W), .IDX_W(IDX_W),
             .FOLD_EN(FOLD_EN)) u_resp (
    .clk(clk), .rst(rst),
    .lkp_valid(lkp_valid), .lkp_pc(lkp_pc),
    .rd_vld(rd_vld), .rd_tag(rd_tag), .rd_target(rd_target),
    .rd_instr(rd_instr), .rd_uncond(rd_uncond),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_next_pc(rsp_next_pc),
    .rsp_instr(rsp_instr), .rsp_fold(rsp_fold)
  );

  // R2: a response is due exactly two edges after its lookup
  a_r2_rsp_latency: assert property (@(posedge clk) disable iff (rst)
    lkp_valid |=> ##1 rsp_valid);

  // R2: no response without a lookup two edges earlier
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !lkp_valid |=> ##1 !rsp_valid);

endmodule

// File: tb/btb_fold_top_test.sv
module btb_fold_top_test;
  localparam int AW = 32;
  localparam int IW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          lkp_valid = 1'b0;
  logic [AW-1:0] lkp_pc = '0;
  logic          upd_valid = 1'b0;
  logic [AW-1:0] upd_pc = '0;
  logic [AW-1:0] upd_target = '0;
  logic          upd_taken = 1'b0;
  logic          upd_uncond = 1'b0;
  logic [IW-1:0] upd_instr = '0;
  logic          rsp_valid, rsp_hit, rsp_fold;
  logic [AW-1:0] rsp_next_pc;
  logic [IW-1:0] rsp_instr;

  always #10 clk = ~clk;  // 50 MHz

  btb_fold_top uut (
    .clk(clk), .rst(rst),
    .lkp_valid(lkp_valid), .lkp_pc(lkp_pc),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_target(upd_target),
    .upd_taken(upd_taken), .upd_uncond(upd_uncond), .upd_instr(upd_instr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_next_pc(rsp_next_pc),
    .rsp_instr(rsp_instr), .rsp_fold(rsp_fold)
  );

  typedef struct {
    logic          hit;
    logic [AW-1:0] nxt;
    logic [IW-1:0] ins;
    logic          fold;
    string         req;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 0;

  // reference table, 16 entries, index pc[5:2], tag pc[31:6]
  logic          m_v   [16];
  logic [25:0]   m_tag [16];
  logic [AW-1:0] m_tgt [16];
  logic [IW-1:0] m_ins [16];
  logic          m_unc [16];

  function automatic exp_t predict(input logic [AW-1:0] pc, input string req);
    exp_t e;
    int i;
    i = int'(pc[5:2]);
    e.req = req;
    e.hit = m_v[i] && (m_tag[i] == pc[31:6]);
    e.nxt = e.hit ? m_tgt[i] : pc + 32'd4;
    e.ins = e.hit ? m_ins[i] : '0;
    e.fold = e.hit && m_unc[i];
    return e;
  endfunction

  // one cycle of stimulus; lookup expectation uses pre-update model (R8)
  task automatic step(input logic lv, input logic [AW-1:0] lpc,
                      input logic uv, input logic [AW-1:0] upc,
                      input logic [AW-1:0] utgt, input logic utk,
                      input logic uunc, input logic [IW-1:0] uins,
                      input string req);
    int i;
    lkp_valid = lv; lkp_pc = lpc;
    upd_valid = uv; upd_pc = upc; upd_target = utgt;
    upd_taken = utk; upd_uncond = uunc; upd_instr = uins;
    if (lv) exp_q.push_back(predict(lpc, req));
    if (uv) begin
      i = int'(upc[5:2]);
      if (utk) begin
        m_v[i] = 1'b1; m_tag[i] = upc[31:6]; m_tgt[i] = utgt;
        m_ins[i] = uins; m_unc[i] = uunc;
      end else if (!uunc) begin
        m_v[i] = 1'b0;
      end
    end
    @(negedge clk);
    lkp_valid = 1'b0; upd_valid = 1'b0;
  endtask

  task automatic look(input logic [AW-1:0] pc, input string req);
    step(1'b1, pc, 1'b0, '0, '0, 1'b0, 1'b0, '0, req);
  endtask

  task automatic upd(input logic [AW-1:0] pc, input logic [AW-1:0] tgt,
                     input logic tk, input logic unc, input logic [IW-1:0] ins);
    step(1'b0, '0, 1'b1, pc, tgt, tk, unc, ins, "");
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // monitor / scoreboard
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (!rst && rsp_valid) begin
        n_chk++;
        if (exp_q.size() == 0) begin
          n_bad++;
          $display("FAIL R2: response with no lookup pending, got valid=1 expected 0");
        end else begin
          e = exp_q.pop_front();
          if (rsp_hit !== e.hit || rsp_next_pc !== e.nxt ||
              rsp_instr !== e.ins || rsp_fold !== e.fold) begin
            n_bad++;
            $display("FAIL %s: got hit=%0b nxt=%h ins=%h fold=%0b expected hit=%0b nxt=%h ins=%h fold=%0b",
                     e.req, rsp_hit, rsp_next_pc, rsp_instr, rsp_fold,
                     e.hit, e.nxt, e.ins, e.fold);
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 16; k++) begin
      m_v[k] = 0; m_tag[k] = '0; m_tgt[k] = '0; m_ins[k] = '0; m_unc[k] = 0;
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: reset state at the ports
    n_chk++;
    if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0 || rsp_fold !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: got valid=%0b hit=%0b fold=%0b expected 0 0 0",
               rsp_valid, rsp_hit, rsp_fold);
    end
    // R1 R4: empty table misses with sequential next PC
    look(32'h0000_0100, "R1");
    look(32'h0000_2000, "R4");
    look(32'hFFFF_FFFC, "R4");
    idle(3);
    // R3 R7: conditional taken, hit without fold
    upd(32'h0000_1040, 32'h0000_8000, 1'b1, 1'b0, 32'hAAAA_0001);
    look(32'h0000_1040, "R3");
    // R7: unconditional folds
    upd(32'h0000_2048, 32'h0000_9000, 1'b1, 1'b1, 32'h1234_5678);
    look(32'h0000_2048, "R7");
    // R5: same index as 0x1040, different tag
    look(32'h0000_2000, "R5");
    look(32'h0001_1040, "R5");
    // R9: overwrite with new target and unconditional mark
    upd(32'h0000_1040, 32'h0000_8800, 1'b1, 1'b1, 32'hBBBB_0002);
    look(32'h0000_1040, "R9");
    // R9: tag replacement at same index evicts old tag
    upd(32'h0000_3040, 32'h0000_A000, 1'b1, 1'b0, 32'hCCCC_0003);
    look(32'h0000_3040, "R9");
    look(32'h0000_1040, "R9");
    // R8: lookup and not-taken clear in the same cycle see old contents
    step(1'b1, 32'h0000_3040, 1'b1, 32'h0000_3040, '0, 1'b0, 1'b0, '0, "R8");
    // R6: entry now gone
    look(32'h0000_3040, "R6");
    // R8: lookup and install in same cycle miss, then hit
    step(1'b1, 32'h0000_4004, 1'b1, 32'h0000_4004, 32'h0000_5000, 1'b1, 1'b0,
         32'hDDDD_0004, "R8");
    look(32'h0000_4004, "R3");
    // R3 R2: fill every index, then stream lookups back to back
    for (int k = 0; k < 16; k++)
      upd(32'h0010_0000 + 32'(k*4), 32'h0020_0000 + 32'(k*16), 1'b1, k[0],
          32'hE000_0000 + 32'(k));
    for (int k = 0; k < 16; k++)
      look(32'h0010_0000 + 32'(k*4), "R3");
    // R6: clear odd indices via not-taken conditionals, then re-read
    for (int k = 1; k < 16; k += 2)
      upd(32'h0010_0000 + 32'(k*4), '0, 1'b0, 1'b0, '0);
    for (int k = 0; k < 16; k++)
      look(32'h0010_0000 + 32'(k*4), "R6");
    idle(4);
    n_chk++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R2: got %0d pending responses expected 0", exp_q.size());
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule